// File: doc/BRIEF.md
# Cascadable Offset Up-Counter

This block is an up-counter built from a chain of narrow counter cells. Each cell is four bits wide by default. Each cell has a synchronous clear, a synchronous parallel load, a count enable, and a carry flag that is high when all of its bits are one. The carry of each cell, ANDed with the enable that reaches that cell, is the enable of the next cell. With the default of two cells, this forms an 8-bit counter in which the upper nibble advances only on the step taken from a lower nibble of 1111.

A control stage sits in front of the cells and turns them into an offset counter. In restart mode, the step taken from the all-ones state loads a programmed start value instead of rolling over to zero. In end mode, a comparator watches for a programmed stop value, and the step taken from that value goes to zero. When both modes are on, the count cycles from the start value to the stop value and then loads the start value again. An external parallel load and a synchronous clear are also available. All controls act only on the rising clock edge.

Top module: `offset_counter_top`

## Requirements
- R1: While `rstN` is low at a rising edge, the count becomes 0 after that edge and `carryOut` is 0.
- R2: `clr` high at an edge makes the count 0 after that edge. It wins over `ldReq`, `cntEn` and both offset modes.
- R3: With `clr` low and `ldReq` high, the count takes `ldValue` at the edge. This happens whether `cntEn` is high or low, and the load wins over counting.
- R4: With `clr`, `ldReq` and `cntEn` all low, the count holds its value.
- R5: With both offset modes off and `cntEn` high, the count advances by one per edge and wraps from 8'hFF to 8'h00.
- R6: `carryOut` is 1 exactly when every bit of the count is 1 (8'hFF by default).
- R7: The upper nibble (bits 7:4) advances only on a counting edge where the lower nibble (bits 3:0) is 4'b1111. For example, 8'h0E goes to 8'h0F and 8'h0F goes to 8'h10.
- R8: With `startMode` high and `cntEn` high, a count of all ones is followed by `startVal`.
- R9: With only `stopMode` high and `cntEn` high, a count equal to `stopVal` is followed by 0.
- R10: With both modes high, a count equal to `stopVal` is followed by `startVal`, so the count cycles over the range start to stop.
- R11: With both modes high and `startVal` greater than `stopVal`, the count climbs to all ones and then reloads `startVal`. It never reaches the stop value from above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear to zero |
| ldReq | input | 1 | Synchronous parallel load of `ldValue` |
| ldValue | input | 8 | Parallel load data |
| cntEn | input | 1 | Count enable |
| startMode | input | 1 | Reload `startVal` in place of wrapping |
| stopMode | input | 1 | Leave the count at `stopVal` on the next step |
| startVal | input | 8 | Programmed start value |
| stopVal | input | 8 | Programmed stop value |
| count | output | 8 | Current count |
| carryOut | output | 1 | High when the count is all ones |

## Verification
The assertions assume that the mode and offset inputs are steady across the edge after which they are checked. They also assume that `startVal` and `stopVal` are only compared against counts that the sequence can actually reach. The stimulus changes every input only on the falling clock edge, so each edge sees one settled combination. It changes the mode and offset values only at row boundaries, and a parallel load places the count near the interesting point before each offset case runs. Priority cases assert `clr`, `ldReq` and `cntEn` together so that the order among the controls is exercised directly.

// File: rtl/offset_counter_pkg.sv
package offset_counter_pkg;

  // Strobes from the control stage into the counter chain
  typedef struct packed {
    logic clear;     // force every cell to zero
    logic load;      // parallel load into every cell
    logic useStart;  // load word is startVal rather than ldValue
    logic step;      // enable for the lowest cell
  } ctr_strobe_t;

endpackage

// File: rtl/counter_cell.sv
module counter_cell #(
  parameter int CELL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              load,
  input  logic [CELL_W-1:0] loadVal,
  input  logic              en,
  output logic [CELL_W-1:0] q,
  output logic              carry
);

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      q <= '0;
    end else if (load) begin
      q <= loadVal;
    end else if (en) begin
      q <= q + CELL_W'(1);
    end
  end

  // Terminal state flag used to chain cells
  assign carry = &q;

endmodule

// File: rtl/counter_datapath.sv
module counter_datapath
  import offset_counter_pkg::*;
#(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2,
  localparam int W      = STAGE_W * STAGES
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctr_strobe_t strb,
  input  logic [W-1:0] ldValue,
  input  logic [W-1:0] startVal,
  output logic [W-1:0] count,
  output logic         topCarry
);

  logic [W-1:0]      loadWord;
  logic [STAGES:0]   chainEn;
  logic [STAGES-1:0] cellCarry;

  assign loadWord   = strb.useStart ? startVal : ldValue;
  assign chainEn[0] = strb.step;

  for (genvar i = 0; i < STAGES; i++) begin : g_cell
    counter_cell #(.CELL_W(STAGE_W)) u_cell (
      .clk    (clk),
      .rstN   (rstN),
      .clear  (strb.clear),
      .load   (strb.load),
      .loadVal(loadWord[i*STAGE_W +: STAGE_W]),
      .en     (chainEn[i]),
      .q      (count[i*STAGE_W +: STAGE_W]),
      .carry  (cellCarry[i])
    );
    // Next cell advances only when this one is enabled and at its top
    assign chainEn[i+1] = chainEn[i] & cellCarry[i];
  end

  assign topCarry = &cellCarry;

endmodule

// File: rtl/counter_control.sv
module counter_control
  import offset_counter_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clr,
  input  logic         ldReq,
  input  logic         cntEn,
  input  logic         startMode,
  input  logic         stopMode,
  input  logic [W-1:0] stopVal,
  input  logic [W-1:0] count,
  input  logic         topCarry,
  output ctr_strobe_t  strb
);

  logic stopHit;
  logic wrapHit;

  assign stopHit = stopMode && (count == stopVal);
  assign wrapHit = startMode && topCarry;

  always_comb begin
    strb = '0;
    if (clr) begin
      strb.clear = 1'b1;
    end else if (ldReq) begin
      strb.load = 1'b1;
    end else if (cntEn) begin
      if (stopHit || wrapHit) begin
        if (startMode) begin
          strb.load     = 1'b1;
          strb.useStart = 1'b1;
        end else begin
          strb.clear = 1'b1;
        end
      end else begin
        strb.step = 1'b1;
      end
    end
  end

endmodule

// File: rtl/offset_counter_top.sv
module offset_counter_top
  import offset_counter_pkg::*;
#(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 2,
  localparam int W      = STAGE_W * STAGES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         ldReq,
  input  logic [W-1:0] ldValue,
  input  logic         cntEn,
  input  logic         startMode,
  input  logic         stopMode,
  input  logic [W-1:0] startVal,
  input  logic [W-1:0] stopVal,
  output logic [W-1:0] count,
  output logic         carryOut
);

  ctr_strobe_t strb;

  counter_control #(.W(W)) u_ctrl (
    .clr      (clr),
    .ldReq    (ldReq),
    .cntEn    (cntEn),
    .startMode(startMode),
    .stopMode (stopMode),
    .stopVal  (stopVal),
    .count    (count),
    .topCarry (carryOut),
    .strb     (strb)
  );

  counter_datapath #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .ldValue (ldValue),
    .startVal(startVal),
    .count   (count),
    .topCarry(carryOut)
  );

endmodule

// File: rtl/offset_counter_chk.sv
module offset_counter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         clr,
  input logic         ldReq,
  input logic [W-1:0] ldValue,
  input logic         cntEn,
  input logic         startMode,
  input logic         stopMode,
  input logic [W-1:0] startVal,
  input logic [W-1:0] stopVal,
  input logic [W-1:0] count,
  input logic         carryOut
);

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |=> (count == '0)); // R1

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0)); // R2

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && ldReq) |=> (count == $past(ldValue))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !ldReq && !cntEn) |=> $stable(count)); // R4

  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !ldReq && cntEn && !startMode && !stopMode)
      |=> (count == W'($past(count) + 1'b1))); // R5

  AST_CARRY_TOP: assert property (@(posedge clk) disable iff (!rstN)
    carryOut == (count == '1)); // R6

  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !ldReq && cntEn && startMode && carryOut)
      |=> (count == $past(startVal))); // R8

  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !ldReq && cntEn && stopMode && !startMode && count == stopVal)
      |=> (count == '0)); // R9

endmodule

bind offset_counter_top offset_counter_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clr      (clr),
  .ldReq    (ldReq),
  .ldValue  (ldValue),
  .cntEn    (cntEn),
  .startMode(startMode),
  .stopMode (stopMode),
  .startVal (startVal),
  .stopVal  (stopVal),
  .count    (count),
  .carryOut (carryOut)
);

// File: tb/tb_offset_counter_top.sv
module tb_offset_counter_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN;
  logic         clr;
  logic         ldReq;
  logic [W-1:0] ldValue;
  logic         cntEn;
  logic         startMode;
  logic         stopMode;
  logic [W-1:0] startVal;
  logic [W-1:0] stopVal;
  logic [W-1:0] count;
  logic         carryOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  offset_counter_top dut (
    .clk(clk), .rstN(rstN), .clr(clr), .ldReq(ldReq), .ldValue(ldValue),
    .cntEn(cntEn), .startMode(startMode), .stopMode(stopMode),
    .startVal(startVal), .stopVal(stopVal), .count(count), .carryOut(carryOut)
  );

  // Row: {req[4], clr, ld, en, startMode, stopMode, ldValue, startVal, stopVal, expected}
  localparam int NV = 22;
  localparam logic [40:0] VEC [NV] = '{
    {4'd3,  5'b01000, 8'h0D, 8'h00, 8'h00, 8'h0D},  // R3 load, enable low
    {4'd4,  5'b00000, 8'h00, 8'h00, 8'h00, 8'h0D},  // R4 hold
    {4'd5,  5'b00100, 8'h00, 8'h00, 8'h00, 8'h0E},  // R5 step
    {4'd7,  5'b00100, 8'h00, 8'h00, 8'h00, 8'h0F},  // R7 upper unchanged
    {4'd7,  5'b00100, 8'h00, 8'h00, 8'h00, 8'h10},  // R7 upper advances
    {4'd3,  5'b01100, 8'hFE, 8'h00, 8'h00, 8'hFE},  // R3 load beats count
    {4'd5,  5'b00100, 8'h00, 8'h00, 8'h00, 8'hFF},  // R5
    {4'd5,  5'b00100, 8'h00, 8'h00, 8'h00, 8'h00},  // R5 wrap
    {4'd3,  5'b01000, 8'hFE, 8'h36, 8'h00, 8'hFE},  // R3
    {4'd8,  5'b00110, 8'h00, 8'h36, 8'h00, 8'hFF},  // R8 approach top
    {4'd8,  5'b00110, 8'h00, 8'h36, 8'h00, 8'h36},  // R8 reload start
    {4'd8,  5'b00110, 8'h00, 8'h36, 8'h00, 8'h37},  // R8 continues
    {4'd9,  5'b00101, 8'h00, 8'h00, 8'h39, 8'h38},  // R9
    {4'd9,  5'b00101, 8'h00, 8'h00, 8'h39, 8'h39},  // R9 reach stop
    {4'd9,  5'b00101, 8'h00, 8'h00, 8'h39, 8'h00},  // R9 stop to zero
    {4'd3,  5'b01000, 8'h37, 8'h36, 8'h38, 8'h37},  // R3
    {4'd10, 5'b00111, 8'h00, 8'h36, 8'h38, 8'h38},  // R10
    {4'd10, 5'b00111, 8'h00, 8'h36, 8'h38, 8'h36},  // R10 stop to start
    {4'd2,  5'b11111, 8'hAA, 8'h36, 8'h38, 8'h00},  // R2 clear wins
    {4'd3,  5'b01000, 8'hFE, 8'hF0, 8'h10, 8'hFE},  // R3
    {4'd11, 5'b00111, 8'h00, 8'hF0, 8'h10, 8'hFF},  // R11 passes stop region
    {4'd11, 5'b00111, 8'h00, 8'hF0, 8'h10, 8'hF0}   // R11 reload start
  };

  task automatic checkVal(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle();
    clr = 0; ldReq = 0; cntEn = 0; startMode = 0; stopMode = 0;
    ldValue = '0; startVal = '0; stopVal = '0;
  endtask

  initial begin
    rstN = 0;
    idle();
    cntEn = 1;
    repeat (2) @(negedge clk);
    checkVal("R1 reset count", count, 8'h00);
    checkBit("R1 reset carry", carryOut, 1'b0);
    rstN = 1;
    cntEn = 0;

    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      {clr, ldReq, cntEn, startMode, stopMode} = v[36:32];
      ldValue  = v[31:24];
      startVal = v[23:16];
      stopVal  = v[15:8];
      @(negedge clk);
      checks++;
      if (count !== v[7:0]) begin
        errors++;
        $display("FAIL R%0d row %0d: actual %h expected %h", v[40:37], i, count, v[7:0]);
      end
      // R6 carry follows the all-ones count
      checkBit("R6 carry", carryOut, (v[7:0] == 8'hFF));
    end

    // R7: hold the lower nibble at 1111 with the counter idle
    idle(); ldReq = 1; ldValue = 8'h2F;
    @(negedge clk);
    idle();
    @(negedge clk);
    checkVal("R7 idle at low top", count, 8'h2F);
    cntEn = 1;
    @(negedge clk);
    checkVal("R7 carry into upper", count, 8'h30);

    // R4: holding with the modes on still changes nothing
    idle(); startMode = 1; stopMode = 1; startVal = 8'h05; stopVal = 8'h30;
    @(negedge clk);
    checkVal("R4 hold with modes", count, 8'h30);

    // R1: reset in the middle of counting
    idle(); cntEn = 1; rstN = 0;
    @(negedge clk);
    checkVal("R1 mid-run reset", count, 8'h00);
    rstN = 1;
    @(negedge clk);
    checkVal("R5 after reset", count, 8'h01);

    idle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule